// File: doc/BRIEF.md
# Write-Protected Two-Wire Serial Memory Slave

This block is a slave on a two-wire serial bus (clock line and open-drain data line) that fronts a 1024-byte register array. Both bus lines are brought into the system clock domain through a synchronizer. The slave finds start and stop conditions on the synchronized lines. It shifts in a control byte, a low address byte and data bytes, and it acknowledges each byte by asserting an output enable that pulls the data line low. On reads it drives the array contents back, most significant bit first.

A static write-protect input turns the whole array into read-only storage. While it is high the slave still acknowledges every byte, so the bus protocol looks the same to the master, but no byte is committed. Three chip-address inputs exist only so the pins can be wired. They are discarded, and the slave answers at one fixed device code. The master's clock is never stretched, and only one master is assumed.

Top module: `wp_twowire_mem`

## Requirements
- R1: A rising data line while the clock line is high (stop) ends any transaction. The slave releases the data line and ignores all later clock pulses until the next start.
- R2: A falling data line while the clock line is high (start) begins a new command from any state, including in the middle of a byte. The partly received byte is discarded.
- R3: The slave changes its data-line drive only while the clock line is low. Received bits are taken at the clock's rising edge, most significant bit first.
- R4: Control byte layout: bits 7:4 must equal 4'b1010, bit 3 is ignored, bits 2:1 select address bits 9:8, and bit 0 is read (1) or write (0). On a match the slave pulls the data line low during the ninth clock. On a mismatch it does not acknowledge and stays silent until the next start.
- R5: A write is a control byte with bit 0 = 0, then the address bits 7:0, then data bytes. Each byte is acknowledged. Each data byte is stored at the pointer, and the pointer then increments, wrapping from 1023 to 0.
- R6: While write-protect is high, control, address and data bytes are all still acknowledged, but the array is left unchanged.
- R7: Write-protect has no effect on reads of any location.
- R8: A read control byte (bit 0 = 1) returns the byte at the pointer, with bits 9:8 taken from that control byte. A random read is a write control byte, then an address byte, then a repeated start, then a read control byte with the same block bits.
- R9: During a read, a master acknowledge (data low on the ninth clock) fetches the next byte, and the address wraps from 1023 to 0. A master no-acknowledge makes the slave release the line and stop driving.
- R10: The three chip-address inputs have no effect on selection or data.
- R11: After reset the slave is idle and does not drive the data line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe_o | output | 1 | 1 pulls the open-drain data line low |
| wp_i | input | 1 | Static write-protect, 1 = array read-only |
| chip_sel_i | input | 3 | Chip-address pins, ignored |

## Verification
The bench builds the block with its default parameters: a 10-bit address (1024 bytes, two block-select bits) and a two-stage synchronizer. With that address width, both the wrap from 1023 to 0 and the block-select decode can be reached with a handful of bytes. The bus runs at 40 system clocks per bit, which leaves ample margin over the synchronizer latency. A repeated start in mid-byte and write-protected writes are each followed by read-back through the bus itself.

// File: rtl/wpm_pkg.sv
// Shared types for the two-wire memory slave.
// Assumes: nothing beyond standard SystemVerilog.
package wpm_pkg;

    // Protocol phase of the slave.
    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_CTRL  = 3'd1,
        PH_ADDR  = 3'd2,
        PH_WRITE = 3'd3,
        PH_READ  = 3'd4
    } phase_t;

endpackage

// File: rtl/wpm_line_sync.sv
// Brings the bus clock and data lines into the system clock domain
// and derives start, stop and clock-edge strobes from them.
// Assumes: STAGES >= 2, and the bus is much slower than clk. Both lines
// reset to the idle-high level so that release of reset creates no edge.
module wpm_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);

    logic [STAGES-1:0] scl_chain;
    logic [STAGES-1:0] sda_chain;
    logic              scl_q;
    logic              sda_q;
    logic              scl_s;
    logic              sda_s;

    // First synchronizer stage for both lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_chain[0] <= 1'b1;
            sda_chain[0] <= 1'b1;
        end else begin
            scl_chain[0] <= scl_i;
            sda_chain[0] <= sda_i;
        end
    end

    // Remaining synchronizer stages, one per extra stage.
    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                scl_chain[g] <= 1'b1;
                sda_chain[g] <= 1'b1;
            end else begin
                scl_chain[g] <= scl_chain[g-1];
                sda_chain[g] <= sda_chain[g-1];
            end
        end
    end

    assign scl_s = scl_chain[STAGES-1];
    assign sda_s = sda_chain[STAGES-1];

    // Previous synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    // Edge and condition decode.
    always_comb begin
        sda_lvl   = sda_s;
        scl_rise  = scl_s & ~scl_q;
        scl_fall  = ~scl_s & scl_q;
        start_evt = scl_s & scl_q & sda_q & ~sda_s;
        stop_evt  = scl_s & scl_q & ~sda_q & sda_s;
    end

endmodule

// File: rtl/wpm_array.sv
// Byte-wide storage array with one write port and one asynchronous read port.
// Assumes: the write enable already includes write protection. The storage
// is deliberately not reset: its contents are defined only by writes.
module wpm_array #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Commit one byte per write strobe.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Combinational read of the addressed byte.
    assign rdata = mem[raddr];

endmodule

// File: rtl/wpm_ctrl.sv
// Protocol engine of the two-wire memory slave: shifts bytes in, decodes
// the control byte, keeps the address pointer, acknowledges, and serializes
// read data onto the open-drain enable.
// Assumes: strobes come from wpm_line_sync; 9 <= ADDR_W <= 11 so that the
// block-select bits fit below the 4-bit device code in the control byte.
module wpm_ctrl
    import wpm_pkg::*;
#(
    parameter int         ADDR_W   = 10,
    parameter logic [3:0] DEV_CODE = 4'b1010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_evt,
    input  logic              stop_evt,
    input  logic              wp_i,
    input  logic [7:0]        rd_data,
    output logic [ADDR_W-1:0] ptr_o,
    output logic [7:0]        wr_data_o,
    output logic              wr_en_o,
    output logic              sda_oe_o,
    output phase_t            phase_o
);

    localparam int BLK_W = ADDR_W - 8;

    phase_t            phase;
    logic [3:0]        bit_cnt;
    logic              in_ack;
    logic [7:0]        shreg;
    logic [7:0]        tx;
    logic [ADDR_W-1:0] ptr;
    logic              oe;
    logic              rd_dir;
    logic              more;
    logic              byte_done;
    logic              wr_commit;

    // A full byte has been shifted in and the clock just fell.
    assign byte_done = scl_fall && !in_ack && (bit_cnt == 4'd8);

    // A received data byte is ready to be stored.
    assign wr_commit = (phase == PH_WRITE) && byte_done && !start_evt && !stop_evt;

    // Main protocol sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            bit_cnt <= '0;
            in_ack  <= 1'b0;
            shreg   <= '0;
            tx      <= '0;
            ptr     <= '0;
            oe      <= 1'b0;
            rd_dir  <= 1'b0;
            more    <= 1'b0;
        end else if (stop_evt) begin
            phase  <= PH_IDLE;
            in_ack <= 1'b0;
            oe     <= 1'b0;
        end else if (start_evt) begin
            phase   <= PH_CTRL;
            bit_cnt <= '0;
            in_ack  <= 1'b0;
            oe      <= 1'b0;
        end else if (phase == PH_READ) begin
            if (scl_rise) begin
                if (bit_cnt == 4'd8) begin
                    more    <= ~sda_lvl;
                    bit_cnt <= 4'd9;
                end else if (bit_cnt < 4'd8) begin
                    bit_cnt <= bit_cnt + 4'd1;
                end
            end else if (scl_fall) begin
                if (bit_cnt == 4'd9) begin
                    if (more) begin
                        tx      <= rd_data;
                        ptr     <= ptr + 1'b1;
                        oe      <= ~rd_data[7];
                        bit_cnt <= '0;
                    end else begin
                        phase <= PH_IDLE;
                        oe    <= 1'b0;
                    end
                end else if (bit_cnt == 4'd8) begin
                    oe <= 1'b0;
                end else if (bit_cnt != 4'd0) begin
                    oe <= ~tx[3'd7 - bit_cnt[2:0]];
                end
            end
        end else if (phase != PH_IDLE) begin
            if (in_ack) begin
                if (scl_fall) begin
                    in_ack  <= 1'b0;
                    oe      <= 1'b0;
                    bit_cnt <= '0;
                    case (phase)
                        PH_CTRL: begin
                            if (rd_dir) begin
                                phase <= PH_READ;
                                tx    <= rd_data;
                                ptr   <= ptr + 1'b1;
                                oe    <= ~rd_data[7];
                            end else begin
                                phase <= PH_ADDR;
                            end
                        end
                        PH_ADDR: phase <= PH_WRITE;
                        default: ;
                    endcase
                end
            end else if (scl_rise && bit_cnt < 4'd8) begin
                shreg   <= {shreg[6:0], sda_lvl};
                bit_cnt <= bit_cnt + 4'd1;
            end else if (byte_done) begin
                case (phase)
                    PH_CTRL: begin
                        if (shreg[7:4] == DEV_CODE) begin
                            in_ack                <= 1'b1;
                            oe                    <= 1'b1;
                            rd_dir                <= shreg[0];
                            ptr[ADDR_W-1:8]       <= shreg[BLK_W:1];
                        end else begin
                            phase <= PH_IDLE;
                        end
                    end
                    PH_ADDR: begin
                        ptr[7:0] <= shreg;
                        in_ack   <= 1'b1;
                        oe       <= 1'b1;
                    end
                    PH_WRITE: begin
                        ptr    <= ptr + 1'b1;
                        in_ack <= 1'b1;
                        oe     <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    // Outputs toward the array and the pad.
    always_comb begin
        ptr_o     = ptr;
        wr_data_o = shreg;
        wr_en_o   = wr_commit & ~wp_i;
        sda_oe_o  = oe;
        phase_o   = phase;
    end

endmodule

// File: rtl/wp_twowire_mem.sv
// Top of the write-protected two-wire memory slave: line synchronizer,
// protocol engine and storage array.
// Assumes: single bus master, no clock stretching, SDA pad is open drain
// driven low while sda_oe_o is 1. Chip-address pins are ignored.
module wp_twowire_mem
    import wpm_pkg::*;
#(
    parameter int         ADDR_W      = 10,
    parameter int         SYNC_STAGES = 2,
    parameter logic [3:0] DEV_CODE    = 4'b1010
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe_o,
    input  logic       wp_i,
    input  logic [2:0] chip_sel_i
);

    logic              sda_lvl;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_evt;
    logic              stop_evt;
    logic [ADDR_W-1:0] ptr;
    logic [7:0]        wr_data;
    logic [7:0]        rd_data;
    logic              arr_we;
    phase_t            phase;
    logic              unused_chip_sel;

    // Chip-address pins are deliberately discarded.
    assign unused_chip_sel = ^chip_sel_i;

    wpm_line_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt)
    );

    wpm_ctrl #(
        .ADDR_W   (ADDR_W),
        .DEV_CODE (DEV_CODE)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt),
        .wp_i      (wp_i),
        .rd_data   (rd_data),
        .ptr_o     (ptr),
        .wr_data_o (wr_data),
        .wr_en_o   (arr_we),
        .sda_oe_o  (sda_oe_o),
        .phase_o   (phase)
    );

    wpm_array #(
        .ADDR_W (ADDR_W),
        .DATA_W (8)
    ) u_array (
        .clk   (clk),
        .we    (arr_we),
        .waddr (ptr),
        .wdata (wr_data),
        .raddr (ptr),
        .rdata (rd_data)
    );

endmodule

// File: rtl/wpm_checker.sv
// Protocol assertions for the two-wire memory slave, bound to the top.
// Assumes: signal names of wp_twowire_mem.
module wpm_checker
    import wpm_pkg::*;
(
    input logic   clk,
    input logic   rst_n,
    input logic   scl_i,
    input logic   wp_i,
    input logic   sda_oe_o,
    input logic   start_evt,
    input logic   stop_evt,
    input logic   arr_we,
    input phase_t phase
);

    // R1: a stop returns the slave to idle with the line released.
    a_r1_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> (phase == PH_IDLE && !sda_oe_o));

    // R2: a start always enters control-byte reception.
    a_r2_start_to_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
        (start_evt && !stop_evt) |=> (phase == PH_CTRL));

    // R3: the data drive moves only while the bus clock is low.
    a_r3_drive_on_low_clock: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_o) |-> !scl_i);

    // R4: an idle (unselected) slave never drives the line.
    a_r4_silent_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE) |-> !sda_oe_o);

    // R6: no array write strobe while write-protect is high.
    a_r6_no_write_when_protected: assert property (@(posedge clk) disable iff (!rst_n)
        wp_i |-> !arr_we);

endmodule

bind wp_twowire_mem wpm_checker chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .wp_i      (wp_i),
    .sda_oe_o  (sda_oe_o),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .arr_we    (arr_we),
    .phase     (phase)
);

// File: tb/wp_twowire_mem_tb_top.sv
// Directed bench for the two-wire memory slave: bus-level master tasks,
// a reference byte model and one task per scenario.
module wp_twowire_mem_tb_top;

    localparam int Q = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       m_low = 1'b0;
    logic       wp = 1'b0;
    logic [2:0] chip_sel = 3'b000;
    logic       sda_oe;
    logic       sda_line;

    int checks = 0;
    int errors = 0;
    int r3_viol = 0;
    logic oe_prev = 1'b0;

    logic [7:0] model [1024];
    logic [7:0] wbuf  [4];

    assign sda_line = !(m_low || sda_oe);

    always #2 clk = ~clk;

    wp_twowire_mem dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl),
        .sda_i      (sda_line),
        .sda_oe_o   (sda_oe),
        .wp_i       (wp),
        .chip_sel_i (chip_sel)
    );

    // R3 monitor: drive changes seen while the clock line is high.
    always @(negedge clk) begin
        if (rst_n && scl && (sda_oe != oe_prev)) r3_viol++;
        oe_prev = sda_oe;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_eq(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        m_low = 1'b0; tick(Q);
        scl = 1'b1;   tick(Q);
        m_low = 1'b1; tick(Q);
        scl = 1'b0;   tick(Q);
    endtask

    task automatic bus_stop();
        m_low = 1'b1; tick(Q);
        scl = 1'b1;   tick(Q);
        m_low = 1'b0; tick(2 * Q);
    endtask

    task automatic send_bit(input logic b);
        m_low = !b; tick(Q);
        scl = 1'b1; tick(2 * Q);
        scl = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        m_low = 1'b0; tick(Q);
        scl = 1'b1;   tick(Q);
        acked = !sda_line; tick(Q);
        scl = 1'b0;   tick(Q);
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic master_ack);
        m_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            tick(Q);
            scl = 1'b1; tick(Q);
            b[i] = sda_line; tick(Q);
            scl = 1'b0; tick(Q);
        end
        m_low = master_ack; tick(Q);
        scl = 1'b1; tick(2 * Q);
        scl = 1'b0; tick(Q);
        m_low = 1'b0;
    endtask

    function automatic logic [7:0] ctrl_byte(input logic [1:0] blk, input logic rd, input logic b3);
        return {4'b1010, b3, blk, rd};
    endfunction

    // Write n bytes from wbuf starting at a; checks every acknowledge.
    task automatic do_write(input logic [9:0] a, input int n, input string req);
        logic ack;
        bus_start();
        send_byte(ctrl_byte(a[9:8], 1'b0, 1'b0), ack);
        check_eq({req, " R4 control ack"}, int'(ack), 1);
        send_byte(a[7:0], ack);
        check_eq({req, " address ack"}, int'(ack), 1);
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], ack);
            check_eq({req, " data ack"}, int'(ack), 1);
            if (!wp) model[10'(a + 10'(i))] = wbuf[i];
        end
        bus_stop();
    endtask

    // Random read of n bytes from a, compared with the model.
    task automatic do_read(input logic [9:0] a, input int n, input logic b3, input string req);
        logic ack;
        logic [7:0] b;
        bus_start();
        send_byte(ctrl_byte(a[9:8], 1'b0, b3), ack);
        send_byte(a[7:0], ack);
        bus_start();
        send_byte(ctrl_byte(a[9:8], 1'b1, b3), ack);
        check_eq({req, " R8 read control ack"}, int'(ack), 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(b, i != n - 1);
            check_eq({req, " read data"}, int'(b), int'(model[10'(a + 10'(i))]));
        end
        bus_stop();
        check_eq({req, " R9 released after nack"}, int'(sda_oe), 0);
    endtask

    task automatic t_reset();
        tick(5);
        check_eq("R11 no drive after reset", int'(sda_oe), 0);
        check_eq("R11 line idle high", int'(sda_line), 1);
    endtask

    task automatic t_write_read();
        wbuf[0] = 8'hA1; wbuf[1] = 8'hB2; wbuf[2] = 8'hC3;
        do_write(10'h110, 3, "R5");
        wbuf[0] = 8'h3C;
        do_write(10'h010, 1, "R5 block0");
        do_read(10'h110, 3, 1'b0, "R8 block1");
        do_read(10'h010, 1, 1'b0, "R4 block0");
    endtask

    task automatic t_bad_code();
        logic ack;
        bus_start();
        send_byte(8'hB0, ack);
        check_eq("R4 wrong code not acked", int'(ack), 0);
        send_byte(8'h10, ack);
        check_eq("R1 ignored until start", int'(ack), 0);
        bus_stop();
        do_read(10'h110, 1, 1'b0, "R4 no stray write");
    endtask

    task automatic t_protect();
        wp = 1'b1;
        wbuf[0] = 8'h5A; wbuf[1] = 8'h6B;
        do_write(10'h110, 2, "R6 protected");
        do_read(10'h110, 2, 1'b0, "R6 R7 array kept, read works");
        wp = 1'b0;
    endtask

    task automatic t_wrap();
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
        do_write(10'h3FE, 4, "R5 wrap");
        do_read(10'h3FE, 4, 1'b0, "R9 sequential wrap");
    endtask

    task automatic t_restart();
        logic ack;
        logic [7:0] b;
        wbuf[0] = 8'h77;
        do_write(10'h020, 1, "R2 setup");
        bus_start();
        send_byte(ctrl_byte(2'b00, 1'b0, 1'b0), ack);
        send_byte(8'h20, ack);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
        bus_start();
        send_byte(ctrl_byte(2'b00, 1'b1, 1'b0), ack);
        check_eq("R2 restart control ack", int'(ack), 1);
        recv_byte(b, 1'b0);
        check_eq("R2 partial byte discarded", int'(b), 32'h77);
        bus_stop();
    endtask

    task automatic t_chip_pins();
        chip_sel = 3'b101;
        do_read(10'h3FF, 1, 1'b1, "R10 chip pins, R4 bit3 ignored");
        chip_sel = 3'b010;
        do_read(10'h110, 1, 1'b0, "R10 chip pins");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_write_read();
        t_bad_code();
        t_protect();
        t_wrap();
        t_restart();
        t_chip_pins();
        check_eq("R3 drive changes with clock high", r3_viol, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule